// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges five reasons to reset a chip into one active-high system reset output. The five reasons are power coming up, an external active-low reset pin, a watchdog expiry pulse, the PLL losing lock, and a software-set reset bit. Each request is qualified and then latched. The sequencer then holds reset until the pin is released and the PLL is locked. After that it stretches reset for a fixed 512-cycle interval, or until a serial boot engine reports completion. A one-hot cause register keeps the reason for the latest reset.

The external pin passes through a two-flop synchroniser and is accepted only after four consecutive low samples. In low-power stop mode the clock is assumed absent. There the pin drives the reset output combinationally, and it is latched without qualification once clocking resumes. Power-good low acts as the block's synchronous active-high reset and forces the power-on state. The PLL-lock input only matters when PLL clock mode is selected.

Top module: `rst_sequencer`

## Requirements
- R1: While `pwr_good_i` is low, `sys_rst_o` is 1, `rst_cause_o` is 5'b00001 and `sw_rst_bit_o` is 0. After power-good, reset is released through the normal wait-and-stretch sequence.
- R2: With `pll_clk_mode_i` high, reset is not released while `pll_lock_i` is low. With `pll_clk_mode_i` low, the lock input is ignored and a low lock raises no request.
- R3: `ext_rst_n_i` passes a two-stage synchroniser. A request is latched on the fourth consecutive edge that samples the synchronised level low. A pin held low across four rising edges raises `sys_rst_o` after the sixth edge. A pin held low across only three edges is ignored.
- R4: While `stop_mode_i` is 1 and the pin is low, `sys_rst_o` is 1 with no clock edge. The synchronised pin is latched as an external request on its first low sample, without the four-sample qualification.
- R5: A watchdog pulse sampled high at a clock edge while not already waiting asserts `sys_rst_o` after that edge.
- R6: In non-serial mode, `sys_rst_o` falls exactly 512 edges after the edge at which the sequencer first sees the pin negated and lock valid. A request seen at edge r with those conditions already met releases at edge r+513.
- R7: In serial boot mode (`serial_boot_i` = 1), reset falls at the edge that samples `boot_done_i` high during the stretch.
- R8: Loss of lock while running asserts reset on the next edge. Release follows relock, then the full stretch.
- R9: Cause bits are: bit0 power-on, bit1 external, bit2 watchdog, bit3 loss-of-lock, bit4 software. The register is always one-hot and is reloaded on each accepted request. For requests at the same edge, priority is external, then watchdog, then loss-of-lock, then software.
- R10: A `sw_rst_wr_i` strobe while running sets `sw_rst_bit_o` at the next edge. That bit raises a request on the following edge. The bit clears one edge after reset asserts and cannot retrigger after release.
- R11: Any request accepted during the stretch returns the sequencer to the wait state, reloads the cause and restarts the full stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| pwr_good_i | input | 1 | Supply valid; low forces power-on reset (synchronous) |
| pll_clk_mode_i | input | 1 | PLL clock mode selected; enables lock gating |
| pll_lock_i | input | 1 | PLL lock indication |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wdt_expire_i | input | 1 | Watchdog timeout pulse |
| sw_rst_wr_i | input | 1 | Write strobe setting the software reset bit |
| serial_boot_i | input | 1 | 1 = stretch ends on boot done, 0 = fixed count |
| boot_done_i | input | 1 | Serial boot sequence finished |
| stop_mode_i | input | 1 | Low-power stop mode, clocks may be stopped |
| sys_rst_o | output | 1 | System reset, active high |
| rst_cause_o | output | 5 | One-hot cause of the latest reset |
| sw_rst_bit_o | output | 1 | Software reset bit |

## Verification
Each result has its own due cycle. A watchdog or lock-loss request shows on `sys_rst_o` right after the edge that samples it. An external request lands six edges after the pin first goes low. The release lands 513 edges after the request edge, counted from the edge at which the pin and lock conditions are first met. In serial mode it lands at the edge that samples boot done. The stimulus tasks drive on falling edges and read a free-running edge counter. From it they compute the exact edge of every expected release and push that edge and the expected cause into a queue. A monitor sampling on falling edges pops an entry on every release and compares edge and cause, so a release one cycle early or late is a miscompare. The combinational stop-mode path is sampled one time unit after the pin changes, before any clock edge.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        SEQ_WAIT    = 2'd0,
        SEQ_STRETCH = 2'd1,
        SEQ_RUN     = 2'd2
    } seq_state_e;

    // one-hot reason record, LSB = power-on
    typedef struct packed {
        logic sw;
        logic lol;
        logic wdt;
        logic ext;
        logic por;
    } rst_cause_t;

    // qualified requests seen in one cycle
    typedef struct packed {
        logic ext;
        logic wdt;
        logic lol;
        logic sw;
    } rst_req_t;

    localparam int CAUSE_W = $bits(rst_cause_t);

    function automatic rst_cause_t cause_power_on();
        rst_cause_t c;
        c     = '0;
        c.por = 1'b1;
        return c;
    endfunction

    // fixed priority: ext, wdt, lol, sw
    function automatic rst_cause_t cause_from_req(input rst_req_t r);
        rst_cause_t c;
        c = '0;
        if (r.ext)      c.ext = 1'b1;
        else if (r.wdt) c.wdt = 1'b1;
        else if (r.lol) c.lol = 1'b1;
        else if (r.sw)  c.sw  = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/rstseq_pin_qual.sv
module rstseq_pin_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_EDGES  = 4
) (
    input  logic clk,
    input  logic por,
    input  logic pin_n,
    input  logic stop,
    output logic pin_ok_o,
    output logic req_o
);
    localparam int CW = (QUAL_EDGES > 1) ? $clog2(QUAL_EDGES) : 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_low;

    // synchroniser starts in the asserted level
    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk) begin
                if (por) sync_q <= '0;
                else     sync_q <= pin_n;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk) begin
                if (por) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            end
        end
    endgenerate

    assign pin_low  = ~sync_q[SYNC_STAGES-1];
    assign pin_ok_o = sync_q[SYNC_STAGES-1];

    generate
        if (QUAL_EDGES > 1) begin : g_qual_cnt
            localparam logic [CW-1:0] LAST = CW'(QUAL_EDGES - 1);
            logic [CW-1:0] low_cnt;

            always_ff @(posedge clk) begin
                if (por || !pin_low)  low_cnt <= '0;
                else if (low_cnt != LAST) low_cnt <= low_cnt + 1'b1;
            end

            assign req_o = pin_low & ((low_cnt == LAST) | stop);

            assert_cnt_reset_R3: assert property (@(posedge clk) disable iff (por)
                $past(!pin_low) |-> (low_cnt == '0));
        end else begin : g_qual_none
            assign req_o = pin_low;
        end
    endgenerate

    assert_qual_hold_R3: assert property (@(posedge clk) disable iff (por)
        (req_o && !stop) |-> $past(pin_low));

endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch #(
    parameter int STRETCH_LEN = 512
) (
    input  logic clk,
    input  logic por,
    input  logic active,
    input  logic serial,
    input  logic boot_done,
    output logic done_o
);
    localparam int CW = $clog2(STRETCH_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(STRETCH_LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (por || !active)    cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    assign done_o = active & (serial ? boot_done : (cnt == LAST));

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (por)
        cnt <= LAST);

    assert_cnt_fresh_R6: assert property (@(posedge clk) disable iff (por)
        (active && !$past(active)) |-> (cnt == '0));

endmodule

// File: rtl/rstseq_cause_log.sv
module rstseq_cause_log
    import rstseq_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  logic       in_run,
    input  logic       take,
    input  rst_req_t   req,
    input  logic       sw_wr,
    output rst_cause_t cause_o,
    output logic       sw_bit_o
);
    rst_cause_t cause_q;
    logic       sw_q;

    always_ff @(posedge clk) begin
        if (por)       cause_q <= cause_power_on();
        else if (take) cause_q <= cause_from_req(req);
    end

    // bit drops as soon as reset is in effect
    always_ff @(posedge clk) begin
        if (por || !in_run) sw_q <= 1'b0;
        else if (sw_wr)     sw_q <= 1'b1;
    end

    assign cause_o  = cause_q;
    assign sw_bit_o = sw_q;

    assert_cause_onehot_R9: assert property (@(posedge clk) disable iff (por)
        $onehot(cause_q));

    assert_ext_first_R9: assert property (@(posedge clk) disable iff (por)
        (take && req.ext) |=> cause_q.ext);

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rstseq_pkg::*;
#(
    parameter int STRETCH_LEN = 512,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_EDGES  = 4
) (
    input  logic               clk,
    input  logic               pwr_good_i,
    input  logic               pll_clk_mode_i,
    input  logic               pll_lock_i,
    input  logic               ext_rst_n_i,
    input  logic               wdt_expire_i,
    input  logic               sw_rst_wr_i,
    input  logic               serial_boot_i,
    input  logic               boot_done_i,
    input  logic               stop_mode_i,
    output logic               sys_rst_o,
    output logic [CAUSE_W-1:0] rst_cause_o,
    output logic               sw_rst_bit_o
);
    logic       por;
    logic       lock_ok;
    logic       pin_ok;
    logic       ext_req;
    logic       stretch_done;
    logic       active;
    logic       in_run;
    logic       any_hit;
    logic       sw_bit;
    rst_req_t   hits;
    rst_cause_t cause;
    seq_state_e state, state_nx;

    assign por     = ~pwr_good_i;
    assign lock_ok = ~pll_clk_mode_i | pll_lock_i;

    rstseq_pin_qual #(
        .SYNC_STAGES(SYNC_STAGES),
        .QUAL_EDGES (QUAL_EDGES)
    ) u_pin (
        .clk     (clk),
        .por     (por),
        .pin_n   (ext_rst_n_i),
        .stop    (stop_mode_i),
        .pin_ok_o(pin_ok),
        .req_o   (ext_req)
    );

    assign active = (state != SEQ_WAIT);
    assign in_run = (state == SEQ_RUN);

    always_comb begin
        hits.ext = ext_req      & active;
        hits.wdt = wdt_expire_i & active;
        hits.lol = ~lock_ok     & active;
        hits.sw  = sw_bit       & active;
    end
    assign any_hit = |hits;

    rstseq_stretch #(
        .STRETCH_LEN(STRETCH_LEN)
    ) u_stretch (
        .clk      (clk),
        .por      (por),
        .active   (state == SEQ_STRETCH),
        .serial   (serial_boot_i),
        .boot_done(boot_done_i),
        .done_o   (stretch_done)
    );

    rstseq_cause_log u_cause (
        .clk     (clk),
        .por     (por),
        .in_run  (in_run),
        .take    (any_hit),
        .req     (hits),
        .sw_wr   (sw_rst_wr_i),
        .cause_o (cause),
        .sw_bit_o(sw_bit)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_WAIT:    if (pin_ok && lock_ok) state_nx = SEQ_STRETCH;
            SEQ_STRETCH: if (any_hit)           state_nx = SEQ_WAIT;
                         else if (stretch_done) state_nx = SEQ_RUN;
            SEQ_RUN:     if (any_hit)           state_nx = SEQ_WAIT;
            default:                            state_nx = SEQ_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por) state <= SEQ_WAIT;
        else     state <= state_nx;
    end

    // stop-mode pin bypasses the clocked path entirely
    assign sys_rst_o    = ~in_run | (stop_mode_i & ~ext_rst_n_i);
    assign rst_cause_o  = cause;
    assign sw_rst_bit_o = sw_bit;

    assert_release_lock_R2: assert property (@(posedge clk) disable iff (por)
        $fell(!in_run) |-> $past(lock_ok));

    assert_wait_exit_R6: assert property (@(posedge clk) disable iff (por)
        ($past(state) == SEQ_WAIT && state == SEQ_STRETCH) |-> $past(pin_ok && lock_ok));

    assert_sw_takes_R10: assert property (@(posedge clk) disable iff (por)
        (sw_bit && in_run) |=> (state == SEQ_WAIT));

    assert_restart_R11: assert property (@(posedge clk) disable iff (por)
        ($past(state) == SEQ_STRETCH && $past(any_hit)) |-> (state == SEQ_WAIT));

endmodule

// File: tb/sim_rst_sequencer.sv
module sim_rst_sequencer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       pwr_good, pll_mode, pll_lock, pin_n, wdt, sw_wr;
    logic       serial, boot_done, stop;
    logic       sys_rst;
    logic [4:0] cause;
    logic       sw_bit;

    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    int unsigned q_at[$];
    logic [4:0]  q_cause[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rst_sequencer u0 (
        .clk           (clk),
        .pwr_good_i    (pwr_good),
        .pll_clk_mode_i(pll_mode),
        .pll_lock_i    (pll_lock),
        .ext_rst_n_i   (pin_n),
        .wdt_expire_i  (wdt),
        .sw_rst_wr_i   (sw_wr),
        .serial_boot_i (serial),
        .boot_done_i   (boot_done),
        .stop_mode_i   (stop),
        .sys_rst_o     (sys_rst),
        .rst_cause_o   (cause),
        .sw_rst_bit_o  (sw_bit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_release(input int unsigned at, input logic [4:0] c, input string tag);
        q_at.push_back(at);
        q_cause.push_back(c);
        q_tag.push_back(tag);
    endtask

    task automatic drain();
        while (q_at.size() != 0) @(negedge clk);
        tick(2);
    endtask

    // monitor: every release must match the head of the queue
    logic prev_rst = 1'b1;
    always @(negedge clk) begin
        if (pwr_good === 1'b1 && prev_rst === 1'b1 && sys_rst === 1'b0) begin
            if (q_at.size() == 0) begin
                chk(1'b0, "R6 unexpected release", int'(cyc), 0);
            end else begin
                int unsigned at;
                logic [4:0]  c;
                string       t;
                at = q_at.pop_front();
                c  = q_cause.pop_front();
                t  = q_tag.pop_front();
                chk(cyc == at, {t, " release edge"}, int'(cyc), int'(at));
                chk(cause === c, {t, " cause"}, int'(cause), int'(c));
            end
        end
        prev_rst = sys_rst;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned c;
        pwr_good = 0; pll_mode = 1; pll_lock = 0; pin_n = 1; wdt = 0; sw_wr = 0;
        serial = 0; boot_done = 0; stop = 0;
        tick(3);
        // R1 reset state
        chk(sys_rst === 1'b1, "R1 reset out", int'(sys_rst), 1);
        chk(cause === 5'b00001, "R1 cause", int'(cause), 1);
        chk(sw_bit === 1'b0, "R1 sw bit", int'(sw_bit), 0);

        // R1/R2 power up, lock late
        pwr_good = 1;
        tick(30);
        chk(sys_rst === 1'b1, "R2 waits for lock", int'(sys_rst), 1);
        c = cyc; pll_lock = 1;
        expect_release(c + 513, 5'b00001, "R1");
        drain();

        // R3 three-edge pulse ignored
        pin_n = 0; tick(3); pin_n = 1; tick(10);
        chk(sys_rst === 1'b0, "R3 short pulse", int'(sys_rst), 0);
        chk(cause === 5'b00001, "R3 cause kept", int'(cause), 1);

        // R3 four-edge pulse
        c = cyc; pin_n = 0;
        expect_release(c + 519, 5'b00010, "R3");
        tick(4); pin_n = 1;
        tick(1);
        chk(sys_rst === 1'b0, "R3 not yet", int'(sys_rst), 0);
        tick(1);
        chk(sys_rst === 1'b1, "R3 asserted edge 6", int'(sys_rst), 1);
        drain();

        // R5 watchdog
        c = cyc; wdt = 1;
        expect_release(c + 514, 5'b00100, "R5");
        tick(1); wdt = 0;
        chk(sys_rst === 1'b1, "R5 asserted", int'(sys_rst), 1);
        drain();

        // R9 priority watchdog over loss-of-lock
        c = cyc; wdt = 1; pll_lock = 0;
        expect_release(c + 514, 5'b00100, "R9");
        tick(1); wdt = 0; pll_lock = 1;
        chk(cause === 5'b00100, "R9 priority", int'(cause), 4);
        drain();

        // R8 loss of lock
        c = cyc; pll_lock = 0;
        tick(1);
        chk(sys_rst === 1'b1, "R8 asserted", int'(sys_rst), 1);
        chk(cause === 5'b01000, "R8 cause", int'(cause), 8);
        tick(19); pll_lock = 1;
        expect_release(c + 533, 5'b01000, "R8");
        drain();

        // R2 lock ignored outside PLL mode
        pll_mode = 0; pll_lock = 0;
        tick(10);
        chk(sys_rst === 1'b0, "R2 lock ignored", int'(sys_rst), 0);
        pll_lock = 1; pll_mode = 1;
        tick(2);

        // R10 software reset
        c = cyc; sw_wr = 1;
        expect_release(c + 515, 5'b10000, "R10");
        tick(1); sw_wr = 0;
        chk(sw_bit === 1'b1, "R10 bit set", int'(sw_bit), 1);
        chk(sys_rst === 1'b0, "R10 not yet", int'(sys_rst), 0);
        tick(1);
        chk(sys_rst === 1'b1, "R10 asserted", int'(sys_rst), 1);
        tick(1);
        chk(sw_bit === 1'b0, "R10 bit cleared", int'(sw_bit), 0);
        drain();
        tick(5);
        chk(sys_rst === 1'b0, "R10 no retrigger", int'(sys_rst), 0);

        // R7 serial boot
        serial = 1;
        c = cyc; wdt = 1;
        tick(1); wdt = 0;
        tick(49);
        chk(sys_rst === 1'b1, "R7 held", int'(sys_rst), 1);
        expect_release(c + 51, 5'b00100, "R7");
        boot_done = 1; tick(1); boot_done = 0;
        drain();
        serial = 0;

        // R11 restart during stretch
        c = cyc; wdt = 1;
        tick(1); wdt = 0;
        tick(99); pll_lock = 0;
        tick(1);
        chk(cause === 5'b01000, "R11 cause reloaded", int'(cause), 8);
        pll_lock = 1;
        expect_release(c + 614, 5'b01000, "R11");
        drain();

        // R4 stop mode
        stop = 1;
        c = cyc; pin_n = 0;
        #1;
        chk(sys_rst === 1'b1, "R4 async assert", int'(sys_rst), 1);
        tick(3);
        chk(cause === 5'b00010, "R4 latched unqualified", int'(cause), 2);
        tick(2); pin_n = 1; stop = 0;
        expect_release(c + 520, 5'b00010, "R4");
        drain();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule